// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Sequencer

This block keeps the contents of an asynchronous DRAM alive. A programmable interval timer produces one refresh obligation every `period` clocks; the refresh period divided by the number of rows gives that value. Obligations go into a small pending counter. While the counter is non-zero the block asks a memory arbiter for the bus. Once the grant arrives it runs one refresh cycle on the strobes and then holds all strobes inactive for the precharge time. Only after that does it withdraw its request. Refreshes may be postponed while the arbiter serves accesses. When the postponed count reaches its limit, an urgent flag tells the arbiter that the next grant must go to refresh.

Each refresh uses one of two styles, chosen by `mode_cbr` when the grant is taken. In the row-addressed style the block drives its own row counter on the address bus and lowers only RAS. In the counter-in-DRAM style it lowers CAS first and drives no address, because the DRAM tracks the row itself. A level request `sr_req` makes the block enter self-refresh as a held CAS-first cycle, and it leaves self-refresh by raising both strobes together. Any refresh obligations still pending are discarded on entry, because the DRAM refreshes itself during that time.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: During and straight after reset, `req`, `urgent` and `addr_en` are 0, and `ras_n`, `cas_n` and `we_n` are 1.
- R2: The block takes on one refresh obligation every `period` clocks (a `period` of 0 acts as 1). When the arbiter grants promptly, successive refresh cycles start exactly `period` clocks apart.
- R3: No strobe falls unless `grant` was high in the cycle before. With `grant` low, pending refreshes put no strobe low.
- R4: With `mode_cbr`=0, a refresh holds `ras_n` low for exactly T_RAS clocks. `cas_n` stays high and `addr_en` is 1, with the row on `addr`.
- R5: The row driven in row-addressed refreshes starts at 0 after reset, advances by one per such refresh and wraps modulo 2^ROW_W. Counter-in-DRAM refreshes leave it unchanged.
- R6: With `mode_cbr`=1, `cas_n` falls first. `ras_n` falls T_CSR clocks later, `cas_n` rises T_CHR clocks after that, and `ras_n` rises T_RHR clocks after `cas_n`. `addr_en` is 0 whenever `cas_n` is low.
- R7: `we_n` is never driven low.
- R8: After `ras_n` rises at the end of any refresh or self-refresh, `req` stays high and all strobes stay high for T_RP clocks. If no work remains, `req` then falls.
- R9: `urgent` rises exactly (PEND_MAX-1)*`period`-1 clocks after `req` rises from an empty pending count with no grant. Further ticks saturate the count. A later grant produces exactly PEND_MAX refreshes.
- R10: A granted `sr_req` enters self-refresh: `cas_n` falls, then `ras_n` falls T_CSR clocks later. `ras_n` stays low for at least SR_MIN clocks, and all pending refreshes are discarded.
- R11: Self-refresh exit raises `ras_n` and `cas_n` in the same clock. If `sr_req` is already low when SR_MIN expires, the exit happens at that point. Otherwise it happens one clock after `sr_req` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | CNT_W | Clocks between refresh obligations |
| mode_cbr | input | 1 | 0: row-addressed refresh, 1: CAS-first refresh |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| grant | input | 1 | Arbiter grant, held while `req` is high |
| req | output | 1 | Bus request toward the arbiter |
| urgent | output | 1 | Postponement limit reached |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row to refresh, zero when not driven |
| addr_en | output | 1 | Address bus drive enable |

## Verification
The hardest situation to reach is saturation of the pending counter, followed by self-refresh entry while that full backlog is waiting. The bench withholds the grant across several intervals until `urgent` is up. It then either releases the grant, to count the catch-up burst, or raises `sr_req` together with the grant. In the second case it checks that the backlog disappears: no row-addressed cycle follows the self-refresh exit. Exit timing is checked with both a request that drops before the minimum hold expires and one held well beyond it.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ROR,
    ST_CBR_CAS,
    ST_CBR_RAS,
    ST_CBR_TAIL,
    ST_SR_CAS,
    ST_SR_HOLD,
    ST_PRE
  } seq_state_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             hold,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  assign last = (period == '0) ? '0 : period - 1'b1;
  assign tick = !hold && (cnt_q >= last);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (hold || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last != '0 && $stable(period)) |=> !tick);
endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
  parameter int PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  input  logic flush,
  output logic work,
  output logic urgent
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] LIMIT = PW'(PEND_MAX);

  logic [PW-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (flush) begin
      pend_d = '0;
    end else begin
      if (tick && pend_q != LIMIT) pend_d = pend_d + 1'b1;
      if (done)                    pend_d = pend_d - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign work   = (pend_q != '0);
  assign urgent = (pend_q == LIMIT);

  assert_pend_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= LIMIT);
  assert_done_has_work_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> work);
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (adv) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row = row_q;

  assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_q != $past(row_q)) |-> (row_q == ROW_W'($past(row_q) + 1'b1)));
endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
  import dram_rfsh_pkg::*;
#(
  parameter int T_RAS  = 6,
  parameter int T_CSR  = 2,
  parameter int T_CHR  = 3,
  parameter int T_RHR  = 2,
  parameter int T_RP   = 5,
  parameter int SR_MIN = 12500,
  parameter int TMR_W  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic work,
  input  logic sr_req,
  input  logic grant,
  input  logic mode_cbr,
  output logic req,
  output logic ras_n,
  output logic cas_n,
  output logic addr_en,
  output logic done_ror,
  output logic done_cbr,
  output logic sr_busy,
  output logic flush
);
  seq_state_e st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    st_d     = st_q;
    tmr_d    = tmr_zero ? tmr_q : tmr_q - 1'b1;
    done_ror = 1'b0;
    done_cbr = 1'b0;
    flush    = 1'b0;
    case (st_q)
      ST_IDLE: if (sr_req || work) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!sr_req && !work) begin
          st_d = ST_IDLE;
        end else if (grant) begin
          if (sr_req) begin
            st_d  = ST_SR_CAS;
            tmr_d = TMR_W'(T_CSR - 1);
            flush = 1'b1;
          end else if (mode_cbr) begin
            st_d  = ST_CBR_CAS;
            tmr_d = TMR_W'(T_CSR - 1);
          end else begin
            st_d  = ST_ROR;
            tmr_d = TMR_W'(T_RAS - 1);
          end
        end
      end
      ST_ROR: if (tmr_zero) begin
        st_d     = ST_PRE;
        tmr_d    = TMR_W'(T_RP - 1);
        done_ror = 1'b1;
      end
      ST_CBR_CAS: if (tmr_zero) begin
        st_d  = ST_CBR_RAS;
        tmr_d = TMR_W'(T_CHR - 1);
      end
      ST_CBR_RAS: if (tmr_zero) begin
        st_d  = ST_CBR_TAIL;
        tmr_d = TMR_W'(T_RHR - 1);
      end
      ST_CBR_TAIL: if (tmr_zero) begin
        st_d     = ST_PRE;
        tmr_d    = TMR_W'(T_RP - 1);
        done_cbr = 1'b1;
      end
      ST_SR_CAS: if (tmr_zero) begin
        st_d  = ST_SR_HOLD;
        tmr_d = TMR_W'(SR_MIN - 1);
      end
      ST_SR_HOLD: if (tmr_zero && !sr_req) begin
        st_d  = ST_PRE;
        tmr_d = TMR_W'(T_RP - 1);
      end
      ST_PRE: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign req     = (st_q != ST_IDLE);
  assign ras_n   = !(st_q inside {ST_ROR, ST_CBR_RAS, ST_CBR_TAIL, ST_SR_HOLD});
  assign cas_n   = !(st_q inside {ST_CBR_CAS, ST_CBR_RAS, ST_SR_CAS, ST_SR_HOLD});
  assign addr_en = (st_q == ST_ROR);
  assign sr_busy = (st_q inside {ST_SR_CAS, ST_SR_HOLD});

  assert_start_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(ras_n) || $fell(cas_n)) && $past(ras_n) && $past(cas_n)) |-> $past(grant));
  assert_ror_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |-> addr_en);
  assert_no_addr_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !addr_en);
  assert_ras_rise_cas_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
  assert_pre_holds_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> req);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROW_W    = 10,
  parameter int CNT_W    = 16,
  parameter int T_RAS    = 6,
  parameter int T_CSR    = 2,
  parameter int T_CHR    = 3,
  parameter int T_RHR    = 2,
  parameter int T_RP     = 5,
  parameter int PEND_MAX = 4,
  parameter int SR_MIN   = 12500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             mode_cbr,
  input  logic             sr_req,
  input  logic             grant,
  output logic             req,
  output logic             urgent,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr,
  output logic             addr_en
);
  localparam int MAX_A = (T_RAS > T_RP)  ? T_RAS : T_RP;
  localparam int MAX_B = (T_CSR > T_CHR) ? T_CSR : T_CHR;
  localparam int MAX_C = (T_RHR > MAX_A) ? T_RHR : MAX_A;
  localparam int MAX_D = (MAX_B > MAX_C) ? MAX_B : MAX_C;
  localparam int MAX_T = (SR_MIN > MAX_D) ? SR_MIN : MAX_D;
  localparam int TMR_W = $clog2(MAX_T + 1);

  logic tick, work, done_ror, done_cbr, sr_busy, flush;
  logic [ROW_W-1:0] row;

  rfsh_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(period), .hold(sr_busy), .tick(tick)
  );

  rfsh_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .tick(tick), .done(done_ror || done_cbr),
    .flush(flush), .work(work), .urgent(urgent)
  );

  rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(done_ror), .row(row)
  );

  rfsh_sequencer #(
    .T_RAS(T_RAS), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RHR(T_RHR),
    .T_RP(T_RP), .SR_MIN(SR_MIN), .TMR_W(TMR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .work(work), .sr_req(sr_req), .grant(grant),
    .mode_cbr(mode_cbr), .req(req), .ras_n(ras_n), .cas_n(cas_n),
    .addr_en(addr_en), .done_ror(done_ror), .done_cbr(done_cbr),
    .sr_busy(sr_busy), .flush(flush)
  );

  assign we_n = 1'b1;
  assign addr = addr_en ? row : '0;
endmodule

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
  localparam int ROW_W = 3, CNT_W = 8, T_RAS = 3, T_CSR = 1, T_CHR = 2;
  localparam int T_RHR = 1, T_RP = 2, PEND_MAX = 3, SR_MIN = 20;

  logic clk = 1'b0, rst_n = 1'b0, mode_cbr = 1'b0, sr_req = 1'b0, allow = 1'b1;
  logic [CNT_W-1:0] period = 8'd9;
  logic req, urgent, ras_n, cas_n, we_n, addr_en, grant;
  logic [ROW_W-1:0] addr;

  assign grant = req & allow;
  always #4 clk = ~clk;

  dram_refresh_ctrl #(.ROW_W(ROW_W), .CNT_W(CNT_W), .T_RAS(T_RAS), .T_CSR(T_CSR),
    .T_CHR(T_CHR), .T_RHR(T_RHR), .T_RP(T_RP), .PEND_MAX(PEND_MAX), .SR_MIN(SR_MIN)) uut (
    .clk(clk), .rst_n(rst_n), .period(period), .mode_cbr(mode_cbr), .sr_req(sr_req),
    .grant(grant), .req(req), .urgent(urgent), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .addr_en(addr_en));

  int n_tests = 0, n_fail = 0, cyc = 0;
  int n_rf, n_rr, n_cf, n_cr, n_qf, n_qr, n_ur;
  int t_rf, t_rr, t_cf, t_cr, t_qf, t_qr, t_ur, addr_at_fall, ae_at_fall;
  int we_low = 0, ae_cas_bad = 0;
  logic p_ras, p_cas, p_req, p_urg;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_rf = 0; n_rr = 0; n_cf = 0; n_cr = 0; n_qf = 0; n_qr = 0; n_ur = 0;
      p_ras = 1'b1; p_cas = 1'b1; p_req = 1'b0; p_urg = 1'b0;
    end else begin
      if (p_ras && !ras_n) begin n_rf++; t_rf = cyc; addr_at_fall = int'(addr); ae_at_fall = int'(addr_en); end
      if (!p_ras && ras_n) begin n_rr++; t_rr = cyc; end
      if (p_cas && !cas_n) begin n_cf++; t_cf = cyc; end
      if (!p_cas && cas_n) begin n_cr++; t_cr = cyc; end
      if (p_req && !req)   begin n_qf++; t_qf = cyc; end
      if (!p_req && req)   begin n_qr++; t_qr = cyc; end
      if (!p_urg && urgent) begin n_ur++; t_ur = cyc; end
      if (!we_n) we_low++;
      if (!cas_n && addr_en) ae_cas_bad++;
      p_ras = ras_n; p_cas = cas_n; p_req = req; p_urg = urgent;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int per, input logic cbr);
    @(negedge clk);
    rst_n = 1'b0; period = CNT_W'(per); mode_cbr = cbr; sr_req = 1'b0; allow = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_rr(input int n);
    while (n_rr < n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_qf(input int n);
    while (n_qf < n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int prev, base, tdrop;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 req", int'(req), 0);
    check_eq("R1 urgent", int'(urgent), 0);
    check_eq("R1 ras_n", int'(ras_n), 1);
    check_eq("R1 cas_n", int'(cas_n), 1);
    check_eq("R1 we_n", int'(we_n), 1);
    check_eq("R1 addr_en", int'(addr_en), 0);

    // R2 R4 R5 R8: row-addressed sweep over several intervals
    foreach (period_list[i]) begin
      do_reset(period_list[i], 1'b0);
      prev = 0;
      for (int k = 0; k < 10; k++) begin
        wait_rr(k + 1);
        wait_qf(k + 1);
        check_eq("R4 ras low width", t_rr - t_rf, T_RAS);
        check_eq("R4 addr_en at ras fall", ae_at_fall, 1);
        check_eq("R5 row sequence", addr_at_fall, k % (1 << ROW_W));
        check_eq("R8 precharge before req drop", t_qf - t_rr, T_RP);
        if (k > 0) check_eq("R2 refresh spacing", t_rf - prev, period_list[i]);
        prev = t_rf;
      end
      check_eq("R4 cas stays high", n_cf, 0);
    end

    // R6 R5: CAS-first cycles between row-addressed ones
    foreach (cbr_list[i]) begin
      do_reset(cbr_list[i], 1'b0);
      wait_rr(3);
      wait_qf(3);
      mode_cbr = 1'b1;
      prev = 0;
      for (int k = 0; k < 4; k++) begin
        wait_rr(4 + k);
        wait_qf(4 + k);
        check_eq("R6 cas to ras", t_rf - t_cf, T_CSR);
        check_eq("R6 ras to cas rise", t_cr - t_rf, T_CHR);
        check_eq("R6 cas rise to ras rise", t_rr - t_cr, T_RHR);
        check_eq("R6 no address", ae_at_fall, 0);
        check_eq("R8 precharge after cbr", t_qf - t_rr, T_RP);
        if (k > 0) check_eq("R2 cbr spacing", t_cf - prev, cbr_list[i]);
        prev = t_cf;
      end
      mode_cbr = 1'b0;
      wait_rr(8);
      check_eq("R5 row unchanged by cbr", addr_at_fall, 3);
    end

    // R9 R3: postponement, urgent, saturation, catch-up burst
    do_reset(40, 1'b0);
    allow = 1'b0;
    while (n_ur < 1) @(posedge clk);
    @(negedge clk);
    check_eq("R9 urgent delay", t_ur - t_qr, (PEND_MAX - 1) * 40 - 1);
    repeat (80) @(negedge clk);
    check_eq("R9 urgent held when saturated", int'(urgent), 1);
    check_eq("R3 no strobe without grant", n_rf + n_cf, 0);
    allow = 1'b1;
    repeat (30) @(negedge clk);
    check_eq("R9 catch-up burst size", n_rf, PEND_MAX);

    // R10 R11: self-refresh with full backlog, short request
    do_reset(40, 1'b0);
    allow = 1'b0;
    while (n_ur < 1) @(posedge clk);
    @(negedge clk);
    sr_req = 1'b1; allow = 1'b1;
    while (n_cf < 1) @(posedge clk);
    @(negedge clk);
    sr_req = 1'b0;
    wait_rr(1);
    wait_qf(1);
    check_eq("R10 cas before ras", t_rf - t_cf, T_CSR);
    check_eq("R10 minimum hold", t_rr - t_rf, SR_MIN);
    check_eq("R11 strobes rise together", t_cr, t_rr);
    check_eq("R8 precharge after self-refresh", t_qf - t_rr, T_RP);
    repeat (20) @(negedge clk);
    check_eq("R10 backlog discarded", n_rf, 1);

    // R11: long request, exit follows request drop
    base = n_cf;
    sr_req = 1'b1;
    while (n_cf < base + 1) @(posedge clk);
    @(negedge clk);
    repeat (60) @(negedge clk);
    sr_req = 1'b0;
    tdrop = cyc;
    wait_rr(2);
    check_eq("R11 exit one clock after drop", t_rr, tdrop + 1);
    check_eq("R11 strobes rise together long", t_cr, t_rr);
    check_eq("R10 held past minimum", int'((t_rr - t_rf) >= SR_MIN), 1);

    // R7 R6: global monitors
    check_eq("R7 we_n never low", we_low, 0);
    check_eq("R6 no address while cas low", ae_cas_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int period_list[3] = '{9, 12, 17};
  int cbr_list[2] = '{10, 15};

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule